// File: doc/BRIEF.md
# Dual-Slot Register Renamer with Branch Snapshots

This block maps architectural register names to physical register tags for a front end that sends two instructions per cycle. Each of the two slots reads two source mappings and may claim one new destination tag from a pool of unused physical registers. The lower slot is older in program order. When the younger slot reads or overwrites a register that the older slot writes in the same cycle, it sees the older slot's fresh tag rather than the stored mapping.

A renamed branch stores a copy of the alias table in one of a small set of snapshot slots. Each live snapshot also records every tag handed out after its branch. A mispredict on the oldest live branch reloads the table from that snapshot and returns all of the recorded tags to the pool in a single cycle. A separate committed map changes only on retirement. Retirement also releases the tag that the retiring instruction displaced. An exception flush rebuilds the alias table from the committed map and marks as free every tag that the committed map does not hold.

Top module: `rn_top`

## Requirements
- R1: After reset, architectural register n maps to physical tag n, tags 32 to 63 are free, no snapshot is live and `rn_ready_o` is high.
- R2: Each valid slot outputs the current tags for both of its sources. Register 0 always reads tag 0. A destination of 0 or a cleared destination enable claims no tag and reports 0 on `rn_pdst_o` and `rn_pold_o`.
- R3: In a cycle where renaming is accepted, slot 0 is given the lowest-numbered free tag and slot 1 the second-lowest. A slot that writes a register removes its tag from the pool.
- R4: A slot 1 source equal to slot 0's written destination reads slot 0's new tag.
- R5: `rn_pold_o` reports the tag the destination held before this rename. If both slots write the same register, slot 1 reports slot 0's new tag and slot 1's mapping is the one that stays.
- R6: `rn_ready_o` is low while fewer than two tags are free. Requests are ignored while it is low.
- R7: A valid slot with its branch flag set takes a snapshot when renaming is accepted. `rn_ready_o` is low while all 4 snapshots are live.
- R8: `br_mispredict_i` restores the table to its state right after the oldest live branch. A branch in slot 0 therefore excludes slot 1's write. Every tag handed out after that branch becomes free on the next cycle, all snapshots are dropped, and `rn_ready_o` is low in that cycle.
- R9: `br_resolve_i` without a mispredict releases the oldest live snapshot. Branches resolve in program order.
- R10: A retire slot writes its tag into the committed map and frees its old tag from the next cycle on. Slot 1 wins when both retire slots name the same register.
- R11: `exc_flush_i` loads the table from the committed map, frees exactly the tags that the committed map does not hold, drops all snapshots and holds `rn_ready_o` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous reset, active high |
| rn_valid_i | input | 2 | slot holds an instruction |
| rn_src_a_i | input | 2x5 | first source register per slot |
| rn_src_b_i | input | 2x5 | second source register per slot |
| rn_dst_i | input | 2x5 | destination register per slot |
| rn_dst_en_i | input | 2 | slot writes a destination |
| rn_branch_i | input | 2 | slot is a branch needing a snapshot |
| rn_ready_o | output | 1 | rename accepted this cycle |
| rn_psrc_a_o | output | 2x6 | first source tag per slot |
| rn_psrc_b_o | output | 2x6 | second source tag per slot |
| rn_pdst_o | output | 2x6 | new destination tag per slot |
| rn_pold_o | output | 2x6 | displaced tag per slot |
| rt_valid_i | input | 2 | retire slot carries a register write |
| rt_arch_i | input | 2x5 | retiring destination register |
| rt_pdst_i | input | 2x6 | retiring new tag |
| rt_pold_i | input | 2x6 | retiring displaced tag to free |
| br_resolve_i | input | 1 | oldest branch predicted correctly |
| br_mispredict_i | input | 1 | oldest branch mispredicted |
| exc_flush_i | input | 1 | exception recovery from committed map |

## Verification
The checks assume well-formed inputs. Retirement happens in program order and never runs past an unresolved branch. Resolves and mispredicts arrive only while a snapshot is live. A flush never coincides with a retire. At most one slot per cycle carries the branch flag, and branches have no destination. The stimulus builds its retire, resolve and mispredict choices from an in-flight queue of accepted renames, so it keeps to these assumptions. Flush cycles are chosen only when no retire is scheduled.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned NUM_ARCH = 32;
    localparam int unsigned NUM_PHYS = 64;
    localparam int unsigned NUM_CKPT = 4;
    localparam int unsigned SLOTS    = 2;
    localparam int unsigned AW = $clog2(NUM_ARCH);
    localparam int unsigned PW = $clog2(NUM_PHYS);
    localparam int unsigned CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1;

    typedef logic [AW-1:0]       areg_t;
    typedef logic [PW-1:0]       preg_t;
    typedef logic [NUM_PHYS-1:0] pmask_t;
    typedef preg_t [NUM_ARCH-1:0] map_t;

    function automatic preg_t low_tag(input pmask_t m);
        preg_t r = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (m[i]) r = preg_t'(i);
        end
        return r;
    endfunction

    function automatic pmask_t tag_bit(input preg_t t);
        pmask_t b = '0;
        b[t] = 1'b1;
        return b;
    endfunction

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < NUM_ARCH; i++) m[i] = preg_t'(i);
        return m;
    endfunction

    function automatic pmask_t boot_free();
        pmask_t f = '0;
        for (int i = NUM_ARCH; i < NUM_PHYS; i++) f[i] = 1'b1;
        return f;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
    import rn_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  pmask_t take_i,
    input  pmask_t give_i,
    input  logic   load_i,
    input  pmask_t load_val_i,
    output pmask_t free_o,
    output preg_t  tag0_o,
    output preg_t  tag1_o,
    output logic   two_ok_o
);
    pmask_t free_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       free_q <= boot_free();
        else if (load_i) free_q <= load_val_i;
        else             free_q <= (free_q & ~take_i) | give_i;
    end

    always_comb begin
        tag0_o   = low_tag(free_q);
        tag1_o   = low_tag(free_q & ~tag_bit(tag0_o));
        two_ok_o = ($countones(free_q) >= 2);
        free_o   = free_q;
    end
endmodule

// File: rtl/rn_ckpt.sv
module rn_ckpt
    import rn_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   push_i,
    input  map_t   push_map_i,
    input  pmask_t push_young_i,
    input  pmask_t take_i,
    input  logic   pop_i,
    input  logic   clear_i,
    output logic   full_o,
    output logic   any_o,
    output map_t   head_map_o,
    output pmask_t head_young_o
);
    logic [NUM_CKPT-1:0] live_w;
    map_t                snap_w  [NUM_CKPT];
    pmask_t              young_w [NUM_CKPT];
    logic [CW-1:0]       head_q, tail_q;
    logic                pop_ok;

    assign pop_ok = pop_i & live_w[head_q];

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push_i) tail_q <= tail_q + 1'b1;
            if (pop_ok) head_q <= head_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_entry
        logic   live_q;
        map_t   snap_q;
        pmask_t young_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                live_q  <= 1'b0;
                snap_q  <= '0;
                young_q <= '0;
            end else if (clear_i) begin
                live_q  <= 1'b0;
            end else if (push_i && tail_q == CW'(g)) begin
                live_q  <= 1'b1;
                snap_q  <= push_map_i;
                young_q <= push_young_i;
            end else begin
                if (pop_ok && head_q == CW'(g)) live_q <= 1'b0;
                if (live_q) young_q <= young_q | take_i;
            end
        end
        assign live_w[g]  = live_q;
        assign snap_w[g]  = snap_q;
        assign young_w[g] = young_q;
    end

    assign full_o       = &live_w;
    assign any_o        = |live_w;
    assign head_map_o   = snap_w[head_q];
    assign head_young_o = young_w[head_q];
endmodule

// File: rtl/rn_rmap.sv
module rn_rmap
    import rn_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic  [SLOTS-1:0]           ret_en_i,
    input  logic  [SLOTS-1:0][AW-1:0]   ret_arch_i,
    input  logic  [SLOTS-1:0][PW-1:0]   ret_new_i,
    output map_t                        rmap_o,
    output pmask_t                      held_o
);
    map_t rmap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rmap_q <= identity_map();
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (ret_en_i[s] && ret_arch_i[s] != '0) rmap_q[ret_arch_i[s]] <= ret_new_i[s];
            end
        end
    end

    always_comb begin
        held_o = '0;
        for (int a = 0; a < NUM_ARCH; a++) held_o = held_o | tag_bit(rmap_q[a]);
        rmap_o = rmap_q;
    end
endmodule

// File: rtl/rn_top.sv
module rn_top
    import rn_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [SLOTS-1:0]          rn_valid_i,
    input  logic [SLOTS-1:0][AW-1:0]  rn_src_a_i,
    input  logic [SLOTS-1:0][AW-1:0]  rn_src_b_i,
    input  logic [SLOTS-1:0][AW-1:0]  rn_dst_i,
    input  logic [SLOTS-1:0]          rn_dst_en_i,
    input  logic [SLOTS-1:0]          rn_branch_i,
    output logic                      rn_ready_o,
    output logic [SLOTS-1:0][PW-1:0]  rn_psrc_a_o,
    output logic [SLOTS-1:0][PW-1:0]  rn_psrc_b_o,
    output logic [SLOTS-1:0][PW-1:0]  rn_pdst_o,
    output logic [SLOTS-1:0][PW-1:0]  rn_pold_o,
    input  logic [SLOTS-1:0]          rt_valid_i,
    input  logic [SLOTS-1:0][AW-1:0]  rt_arch_i,
    input  logic [SLOTS-1:0][PW-1:0]  rt_pdst_i,
    input  logic [SLOTS-1:0][PW-1:0]  rt_pold_i,
    input  logic                      br_resolve_i,
    input  logic                      br_mispredict_i,
    input  logic                      exc_flush_i
);
    map_t   map_q, mid_map, full_map, rmap, head_map, push_map;
    pmask_t free_mask, held, head_young, take, rel, give, push_young;
    preg_t  tag [SLOTS];
    logic   [SLOTS-1:0] wr, rt_ok;
    logic   two_ok, ck_full, ck_any, misp_ok, push;

    // Acceptance does not depend on the request, only on resources and recovery.
    assign rn_ready_o = ~exc_flush_i & ~br_mispredict_i & two_ok & ~ck_full;
    assign misp_ok    = br_mispredict_i & ck_any & ~exc_flush_i;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign wr[s]    = rn_ready_o & rn_valid_i[s] & rn_dst_en_i[s] & (rn_dst_i[s] != '0);
        assign rt_ok[s] = rt_valid_i[s] & (rt_arch_i[s] != '0);
    end

    // Reads, with slot 1 forwarded from slot 0's fresh tag.
    always_comb begin
        rn_psrc_a_o[0] = map_q[rn_src_a_i[0]];
        rn_psrc_b_o[0] = map_q[rn_src_b_i[0]];
        rn_psrc_a_o[1] = (wr[0] && rn_src_a_i[1] == rn_dst_i[0]) ? tag[0] : map_q[rn_src_a_i[1]];
        rn_psrc_b_o[1] = (wr[0] && rn_src_b_i[1] == rn_dst_i[0]) ? tag[0] : map_q[rn_src_b_i[1]];
        rn_pdst_o[0]   = wr[0] ? tag[0] : '0;
        rn_pdst_o[1]   = wr[1] ? tag[1] : '0;
        rn_pold_o[0]   = wr[0] ? map_q[rn_dst_i[0]] : '0;
        rn_pold_o[1]   = !wr[1] ? '0 :
                         (wr[0] && rn_dst_i[1] == rn_dst_i[0]) ? tag[0] : map_q[rn_dst_i[1]];
    end

    // Table after slot 0 and after both slots; the snapshot picks one.
    always_comb begin
        mid_map = map_q;
        if (wr[0]) mid_map[rn_dst_i[0]] = tag[0];
        full_map = mid_map;
        if (wr[1]) full_map[rn_dst_i[1]] = tag[1];
        take = '0;
        rel  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (wr[s])    take = take | tag_bit(tag[s]);
            if (rt_ok[s]) rel  = rel | tag_bit(rt_pold_i[s]);
        end
        push       = rn_ready_o & |(rn_valid_i & rn_branch_i);
        push_map   = (rn_valid_i[0] && rn_branch_i[0]) ? mid_map : full_map;
        push_young = (rn_valid_i[0] && rn_branch_i[0] && wr[1]) ? tag_bit(tag[1]) : '0;
        give       = rel | (misp_ok ? head_young : '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)            map_q <= identity_map();
        else if (exc_flush_i) map_q <= rmap;
        else if (misp_ok)     map_q <= head_map;
        else                  map_q <= full_map;
    end

    rn_freelist u_free (
        .clk_i(clk_i), .rst_i(rst_i), .take_i(take), .give_i(give),
        .load_i(exc_flush_i), .load_val_i(~held), .free_o(free_mask),
        .tag0_o(tag[0]), .tag1_o(tag[1]), .two_ok_o(two_ok)
    );

    rn_ckpt u_ckpt (
        .clk_i(clk_i), .rst_i(rst_i), .push_i(push), .push_map_i(push_map),
        .push_young_i(push_young), .take_i(take),
        .pop_i(br_resolve_i & ~br_mispredict_i & ~exc_flush_i),
        .clear_i(exc_flush_i | misp_ok), .full_o(ck_full), .any_o(ck_any),
        .head_map_o(head_map), .head_young_o(head_young)
    );

    rn_rmap u_rmap (
        .clk_i(clk_i), .rst_i(rst_i), .ret_en_i(rt_valid_i), .ret_arch_i(rt_arch_i),
        .ret_new_i(rt_pdst_i), .rmap_o(rmap), .held_o(held)
    );
endmodule

// File: rtl/rn_top_chk.sv
module rn_top_chk
    import rn_pkg::*;
(
    input logic                      clk_i,
    input logic                      rst_i,
    input logic [SLOTS-1:0]          rn_valid_i,
    input logic [SLOTS-1:0][AW-1:0]  rn_src_a_i,
    input logic [SLOTS-1:0][AW-1:0]  rn_dst_i,
    input logic [SLOTS-1:0]          rn_dst_en_i,
    input logic                      rn_ready_o,
    input logic [SLOTS-1:0][PW-1:0]  rn_psrc_a_o,
    input logic [SLOTS-1:0][PW-1:0]  rn_pdst_o,
    input logic [SLOTS-1:0]          rt_valid_i,
    input logic                      br_mispredict_i,
    input logic                      exc_flush_i,
    input pmask_t                    free_mask,
    input logic                      ck_full
);
    logic w0, w1;
    assign w0 = rn_ready_o & rn_valid_i[0] & rn_dst_en_i[0] & (rn_dst_i[0] != '0);
    assign w1 = rn_ready_o & rn_valid_i[1] & rn_dst_en_i[1] & (rn_dst_i[1] != '0);

    p_zero_fixed_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (rn_ready_o && rn_valid_i[0] && rn_src_a_i[0] == '0) |-> rn_psrc_a_o[0] == '0);
    p_tags_differ_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (w0 && w1) |-> rn_pdst_o[0] != rn_pdst_o[1]);
    p_tag_was_free_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        w0 |-> free_mask[rn_pdst_o[0]]);
    p_tag_taken_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        w1 |=> !free_mask[$past(rn_pdst_o[1])]);
    p_pair_forward_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (w0 && rn_valid_i[1] && rn_src_a_i[1] == rn_dst_i[0]) |-> rn_psrc_a_o[1] == rn_pdst_o[0]);
    p_low_pool_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(free_mask) < 2) |-> !rn_ready_o);
    p_snap_full_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ck_full |-> !rn_ready_o);
    p_recover_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        br_mispredict_i |-> !rn_ready_o);
    p_flush_alone_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        exc_flush_i |-> (rt_valid_i == '0 && !rn_ready_o));
endmodule

bind rn_top rn_top_chk chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .rn_valid_i(rn_valid_i), .rn_src_a_i(rn_src_a_i),
    .rn_dst_i(rn_dst_i), .rn_dst_en_i(rn_dst_en_i), .rn_ready_o(rn_ready_o),
    .rn_psrc_a_o(rn_psrc_a_o), .rn_pdst_o(rn_pdst_o), .rt_valid_i(rt_valid_i),
    .br_mispredict_i(br_mispredict_i), .exc_flush_i(exc_flush_i),
    .free_mask(free_mask), .ck_full(ck_full)
);

// File: tb/rn_top_tb_top.sv
`timescale 1ns/1ps
module rn_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0]      v, de, br, rv;
    logic [1:0][4:0] sa, sb, d, ra;
    logic [1:0][5:0] rp, rpo;
    logic            res, misp, exc;
    logic            rdy;
    logic [1:0][5:0] psa, psb, pd, po;

    rn_top dut_i (
        .clk_i(clk), .rst_i(rst), .rn_valid_i(v), .rn_src_a_i(sa), .rn_src_b_i(sb),
        .rn_dst_i(d), .rn_dst_en_i(de), .rn_branch_i(br), .rn_ready_o(rdy),
        .rn_psrc_a_o(psa), .rn_psrc_b_o(psb), .rn_pdst_o(pd), .rn_pold_o(po),
        .rt_valid_i(rv), .rt_arch_i(ra), .rt_pdst_i(rp), .rt_pold_i(rpo),
        .br_resolve_i(res), .br_mispredict_i(misp), .exc_flush_i(exc)
    );

    int checks = 0, errors = 0;
    string cur_req = "R1";
    int m_map[32], m_rmap[32];
    bit m_free[64];
    int ck_flat[$];
    int ck_n = 0;
    int q_arch[$], q_pdst[$], q_pold[$], q_wr[$], q_br[$]; // q_br: 0 none, 1 open branch, 2 resolved

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    function automatic int pool_size();
        int n = 0;
        for (int i = 0; i < 64; i++) n += m_free[i];
        return n;
    endfunction

    function automatic int first_free(int skip);
        for (int i = 0; i < 64; i++) if (m_free[i] && i != skip) return i;
        return 0;
    endfunction

    task automatic idle();
        v = 0; de = 0; br = 0; sa = 0; sb = 0; d = 0;
        rv = 0; ra = 0; rp = 0; rpo = 0; res = 0; misp = 0; exc = 0;
    endtask

    task automatic q_pop();
        void'(q_arch.pop_front()); void'(q_pdst.pop_front()); void'(q_pold.pop_front());
        void'(q_wr.pop_front()); void'(q_br.pop_front());
    endtask

    task automatic q_push(int a, int p, int o, int w, int b);
        q_arch.push_back(a); q_pdst.push_back(p); q_pold.push_back(o);
        q_wr.push_back(w); q_br.push_back(b);
    endtask

    // Choose retirements from the head of the in-flight queue (R10).
    task automatic pick_retire(int pct);
        for (int s = 0; s < 2; s++) begin
            while (q_br.size() > 0 && q_br[0] == 2) q_pop();
            if (q_br.size() > 0 && q_br[0] == 0 && $urandom_range(99) < pct) begin
                rv[s] = 1; ra[s] = 5'(q_arch[0]); rp[s] = 6'(q_pdst[0]); rpo[s] = 6'(q_pold[0]);
                q_pop();
            end
        end
    endtask

    // One clock: compare outputs against the model, then advance the model.
    task automatic cycle();
        int t0, t1, e;
        bit er, w0, w1;
        #1;
        t0 = first_free(-1);
        t1 = first_free(t0);
        er = !exc && !misp && pool_size() >= 2 && ck_n < 4;
        chk(rdy == er, "ready", int'(rdy), int'(er));
        w0 = er && v[0] && de[0] && d[0] != 0;
        w1 = er && v[1] && de[1] && d[1] != 0;
        if (er) begin
            if (v[0]) begin
                chk(psa[0] == 6'(m_map[sa[0]]), "slot0 src a", int'(psa[0]), m_map[sa[0]]);
                chk(psb[0] == 6'(m_map[sb[0]]), "slot0 src b", int'(psb[0]), m_map[sb[0]]);
            end
            if (v[1]) begin
                e = (w0 && sa[1] == d[0]) ? t0 : m_map[sa[1]];
                chk(psa[1] == 6'(e), "slot1 src a", int'(psa[1]), e);
                e = (w0 && sb[1] == d[0]) ? t0 : m_map[sb[1]];
                chk(psb[1] == 6'(e), "slot1 src b", int'(psb[1]), e);
            end
            e = w0 ? t0 : 0;
            chk(pd[0] == 6'(e), "slot0 dst tag", int'(pd[0]), e);
            e = w0 ? m_map[d[0]] : 0;
            chk(po[0] == 6'(e), "slot0 old tag", int'(po[0]), e);
            e = w1 ? t1 : 0;
            chk(pd[1] == 6'(e), "slot1 dst tag", int'(pd[1]), e);
            e = !w1 ? 0 : (w0 && d[1] == d[0]) ? t0 : m_map[d[1]];
            chk(po[1] == 6'(e), "slot1 old tag", int'(po[1]), e);
        end
        @(posedge clk);
        for (int s = 0; s < 2; s++) if (rv[s] && ra[s] != 0) m_rmap[ra[s]] = int'(rp[s]);
        if (exc) begin
            for (int i = 0; i < 64; i++) m_free[i] = 1;
            for (int a = 0; a < 32; a++) begin m_map[a] = m_rmap[a]; m_free[m_rmap[a]] = 0; end
            ck_flat.delete(); ck_n = 0;
            q_arch.delete(); q_pdst.delete(); q_pold.delete(); q_wr.delete(); q_br.delete();
        end else if (misp && ck_n > 0) begin
            int k = 0;
            while (q_br[k] != 1) k++;
            while (q_br.size() > k + 1) begin
                if (q_wr[q_br.size()-1]) m_free[q_pdst[q_br.size()-1]] = 1;
                void'(q_arch.pop_back()); void'(q_pdst.pop_back()); void'(q_pold.pop_back());
                void'(q_wr.pop_back()); void'(q_br.pop_back());
            end
            q_br[k] = 2;
            for (int a = 0; a < 32; a++) m_map[a] = ck_flat[a];
            ck_flat.delete(); ck_n = 0;
        end else begin
            if (res && ck_n > 0) begin
                for (int a = 0; a < 32; a++) void'(ck_flat.pop_front());
                ck_n--;
                for (int k = 0; k < q_br.size(); k++) if (q_br[k] == 1) begin q_br[k] = 2; break; end
            end
            if (er) begin
                for (int s = 0; s < 2; s++) begin
                    if ((s == 0 && w0) || (s == 1 && w1)) begin
                        int t = (s == 0) ? t0 : t1;
                        q_push(d[s], t, m_map[d[s]], 1, 0);
                        m_map[d[s]] = t; m_free[t] = 0;
                    end
                    if (v[s] && br[s]) begin
                        q_push(0, 0, 0, 0, 1);
                        for (int a = 0; a < 32; a++) ck_flat.push_back(m_map[a]);
                        ck_n++;
                    end
                end
            end
        end
        for (int s = 0; s < 2; s++) if (rv[s] && ra[s] != 0) m_free[rpo[s]] = 1;
        @(negedge clk);
    endtask

    task automatic pair(int d0, int a0, int b0, int d1, int a1, int b1);
        idle();
        v = 2'b11; de = 2'b11;
        d[0] = 5'(d0); sa[0] = 5'(a0); sb[0] = 5'(b0);
        d[1] = 5'(d1); sa[1] = 5'(a1); sb[1] = 5'(b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL %s watchdog actual 0 expected 1", cur_req);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        for (int a = 0; a < 32; a++) begin m_map[a] = a; m_rmap[a] = a; end
        for (int i = 0; i < 64; i++) m_free[i] = (i >= 32);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: identity map and pool after reset, read with no writes
        cur_req = "R1";
        for (int i = 0; i < 8; i++) begin
            idle(); v = 2'b11;
            sa[0] = 5'(4*i); sb[0] = 5'(4*i+1); sa[1] = 5'(4*i+2); sb[1] = 5'(4*i+3);
            cycle();
        end

        // R4 R5: dependent pair, R1 = R2*R3 then R3 = R1+R3
        cur_req = "R4";
        pair(1, 2, 3, 3, 1, 3); cycle();
        cur_req = "R5";
        pair(7, 1, 3, 7, 7, 2); cycle();
        // R2: register 0 reads tag 0, destination 0 claims nothing
        cur_req = "R2";
        pair(0, 0, 1, 0, 0, 7); cycle();
        pair(4, 0, 0, 9, 4, 0); de[1] = 0; cycle();

        // R6: drain the pool until renaming stalls
        cur_req = "R6";
        for (int i = 0; i < 20; i++) begin pair(i % 31 + 1, 3, 7, (i + 5) % 31 + 1, i % 31 + 1, 1); cycle(); end
        // R11: flush rebuilds from the committed map
        cur_req = "R11";
        idle(); exc = 1; cycle();
        idle(); v = 2'b11; sa[0] = 1; sb[0] = 3; sa[1] = 7; sb[1] = 4; cycle();

        // R7: four snapshots with a younger write in slot 1
        cur_req = "R7";
        for (int i = 0; i < 5; i++) begin pair(0, 0, 0, 5, 5, 6); de[0] = 0; br[0] = 1; cycle(); end
        // R9: resolve the oldest, renaming resumes next cycle
        cur_req = "R9";
        idle(); res = 1; cycle();
        pair(6, 5, 6, 5, 6, 5); cycle();
        // R8: mispredict the oldest live branch
        cur_req = "R8";
        pair(2, 2, 2, 2, 2, 2); misp = 1; cycle();
        idle(); v = 2'b11; sa[0] = 5; sb[0] = 6; sa[1] = 2; cycle();
        pair(8, 5, 6, 9, 8, 5); cycle();

        // R10: random traffic with retirement, branches and recovery
        cur_req = "R10";
        for (int n = 0; n < 4000; n++) begin
            idle();
            if ($urandom_range(99) < 80) begin
                for (int s = 0; s < 2; s++) begin
                    v[s] = 1; de[s] = ($urandom_range(3) != 0);
                    d[s]  = 5'($urandom_range(3) == 0 ? $urandom_range(31) : $urandom_range(5));
                    sa[s] = 5'($urandom_range(3) == 0 ? $urandom_range(31) : $urandom_range(5));
                    sb[s] = 5'($urandom_range(5));
                end
                if ($urandom_range(5) == 0) begin
                    int bs = $urandom_range(1);
                    br[bs] = 1; de[bs] = 0;
                end
            end
            pick_retire(70);
            if (ck_n > 0 && $urandom_range(99) < 30) res = 1;
            if (ck_n > 0 && $urandom_range(99) < 5) misp = 1;
            if (rv == 0 && $urandom_range(99) < 1) exc = 1;
            cycle();
        end

        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule